// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an eight-bit counter with one compare channel. It drives a single waveform pin and raises two interrupt requests, one for count overflow and one for compare match. Software controls it through a small register bus. The bus gives access to a control byte, the live count, the compare value, an interrupt mask and a flag register.

The counter advances on timer ticks. A tick comes from one of three places, chosen by a clock-select field: the system clock divided by 1, 8, 64, 256 or 1024; a synchronised external pin, counting on its rising or falling edge; or nothing, in which case the count is frozen. A two-bit mode field picks the counting pattern. The modes are a free-running up-count, an up-count that restarts on compare, a saw-tooth PWM and a triangle PWM. A two-bit action field then decides how a compare event moves the waveform pin. A strobe bit in the control byte can fire the compare action at once, without a real compare event.

Writes take effect on the clock edge that samples them. Read data is registered, so it appears one cycle after the address is presented.

Top module: `wave_timer8`

## Requirements
- R1: Clock select is control bits [2:0]. Code 0 freezes the count. Codes 1 to 5 tick once every 1, 8, 64, 256 or 1024 system clocks. Over any 80 consecutive clocks, code 2 advances the count by exactly 10.
- R2: Clock select 7 advances the count once per rising edge of the external pin. Code 6 advances it once per falling edge. The pin passes through a two-stage synchroniser.
- R3: Mode is control bits [4:3]. In mode 0 the count only rises and wraps from 0xFF to 0x00. Overflow flag bit 0 is set on the same edge that the count becomes 0x00.
- R4: In mode 2, a tick that finds the count equal to the compare value sets compare flag bit 1 and sends the count to zero. With action 1 (toggle) the pin flips on each such tick, so a compare value of N gives a period of 2·(N+1) ticks.
- R5: In mode 2 with toggle action and a compare value of zero, the pin flips on every tick.
- R6: Mode 3 counts 0 to 0xFF and wraps, setting the overflow flag at the wrap. Action 2 sets the pin at the wrap and clears it on match, so the pin is high for compare+1 of every 256 ticks. Action 3 does the opposite.
- R7: Mode 1 counts up to 0xFF, stays there for one tick, then counts down to 0x00, stays there for one tick, and rises again. With action 2, a match while rising clears the pin and a match while falling sets it. Action 3 does the opposite. The overflow flag is set on the tick where the count steps from 1 to 0.
- R8: In modes 1 and 3 a compare write is held in a buffer and takes effect only at the top of the count. In modes 0 and 2 it takes effect on the write edge.
- R9: Control bit 7 is a strobe. In modes 0 and 2 it applies the action written with it on that edge (1 toggle, 2 clear, 3 set). It sets no flag, leaves the count alone and always reads back as 0. In modes 1 and 3 it does nothing.
- R10: Writing 1 to a flag bit clears it. Each interrupt request is its flag ANDed with the matching mask bit (mask bit 0 for overflow, bit 1 for compare).
- R11: After reset, every register reads zero, the pin is low and both requests are low. The register addresses are: 0 control, 1 count, 2 compare, 3 mask, 4 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | CNT_W (8) | Write data |
| bus_rdata | output | CNT_W (8) | Registered read data, valid one cycle after the address |
| ext_clk_in | input | 1 | External count source, asynchronous |
| wave_out | output | 1 | Compare waveform pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |

## Verification
Every register in the path is counted. With a divide-by-one clock, the first tick falls on the edge after the control write, and a tick that processes count value v lands k edges after that write, where k is v minus the start value plus one. The pin and the requests therefore change on exactly that edge. The bench steps through falling clock edges and samples one cycle before and one cycle after each predicted edge: after 3 edges for the free-running overflow from 0xFD, after 129, 383 and 510 edges for the triangle mode, and after 49 and 240 edges for the buffered compare. Reads are taken one cycle after the address because read data is registered. Prescaler and external-pin counts are read only after the count is frozen, so the phase of the synchroniser and the prescaler cannot shift the result.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  typedef enum logic [1:0] {
    WM_FREE = 2'd0,
    WM_TRI  = 2'd1,
    WM_CLR  = 2'd2,
    WM_SAW  = 2'd3
  } wmode_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_CMP   = 3'd2;
  localparam logic [2:0] A_MASK  = 3'd3;
  localparam logic [2:0] A_FLAG  = 3'd4;

  function automatic logic is_pwm(wmode_e m);
    return (m == WM_TRI) || (m == WM_SAW);
  endfunction

  // number of low prescaler bits that must be all ones for a tick
  function automatic int unsigned div_log2(logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wtmr_clkgen.sv
module wtmr_clkgen
  import wtmr_pkg::*;
#(
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       ext_in,
  output logic       tick
);

  logic [PSC_W-1:0]       psc_q;
  logic [PSC_W-1:0]       psc_mask;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_now;

  always_ff @(posedge clk) begin
    if (rst) psc_q <= '0;
    else     psc_q <= psc_q + 1'b1;
  end

  // synchroniser depth is chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
    end
  endgenerate

  assign ext_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) ext_prev_q <= 1'b0;
    else     ext_prev_q <= ext_now;
  end

  always_comb begin
    psc_mask = PSC_W'((32'd1 << div_log2(sel)) - 32'd1);
    case (sel)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd6:    tick = ext_prev_q & ~ext_now;
      3'd7:    tick = ~ext_prev_q & ext_now;
      default: tick = ((psc_q & psc_mask) == psc_mask);
    endcase
  end

endmodule

// File: rtl/wtmr_core.sv
module wtmr_core
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wmode_e           mode,
  input  logic [1:0]       act,
  input  logic             force_req,
  input  wmode_e           force_mode,
  input  logic [1:0]       force_act,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] cmp_next,
  output logic [CNT_W-1:0] cnt_q,
  output logic             oc_q,
  output logic             ovf_evt,
  output logic             cmp_evt
);

  localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONEV  = CNT_W'(1);

  logic [CNT_W-1:0] cmp_act_q;
  logic [CNT_W-1:0] cnt_d;
  logic             up_q, up_d;
  logic             oc_d;
  logic             match, at_max, top;

  assign match  = tick && (cnt_q == cmp_act_q);
  assign at_max = (cnt_q == MAXV);
  assign cmp_evt = match;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    ovf_evt = 1'b0;
    top     = 1'b0;
    if (mode != WM_TRI) up_d = 1'b1;
    if (tick) begin
      case (mode)
        WM_FREE: begin
          cnt_d   = cnt_q + 1'b1;
          ovf_evt = at_max;
        end
        WM_CLR: begin
          cnt_d   = match ? '0 : cnt_q + 1'b1;
          ovf_evt = at_max && !match;
        end
        WM_SAW: begin
          cnt_d   = cnt_q + 1'b1;
          ovf_evt = at_max;
          top     = at_max;
        end
        default: begin
          if (up_q) begin
            if (at_max) begin
              cnt_d = MAXV - 1'b1;
              up_d  = 1'b0;
              top   = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = ONEV;
              up_d  = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
            ovf_evt = (cnt_q == ONEV);
          end
        end
      endcase
    end
    if (cnt_wr) cnt_d = cnt_wdata;
  end

  always_comb begin
    oc_d = oc_q;
    if (tick) begin
      case (mode)
        WM_SAW: begin
          if (act[1]) begin
            if (top)        oc_d = ~act[0];
            else if (match) oc_d = act[0];
          end
        end
        WM_TRI: begin
          if (match && act[1]) oc_d = act[0] ? up_q : ~up_q;
        end
        default: begin
          if (match) begin
            case (act)
              2'd1:    oc_d = ~oc_q;
              2'd2:    oc_d = 1'b0;
              2'd3:    oc_d = 1'b1;
              default: oc_d = oc_q;
            endcase
          end
        end
      endcase
    end
    if (force_req && !is_pwm(force_mode)) begin
      case (force_act)
        2'd1:    oc_d = ~oc_q;
        2'd2:    oc_d = 1'b0;
        2'd3:    oc_d = 1'b1;
        default: oc_d = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      up_q      <= 1'b1;
      oc_q      <= 1'b0;
      cmp_act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      oc_q  <= oc_d;
      if (!is_pwm(mode) || top) cmp_act_q <= cmp_next;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt_q)); // R1

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == WM_FREE && at_max && !cnt_wr) |=> (cnt_q == '0)); // R3

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == WM_CLR && cnt_q == cmp_act_q && !cnt_wr) |=> (cnt_q == '0)); // R4

  AST_TRI_BOUNCE: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == WM_TRI && up_q && at_max && !cnt_wr) |=> (!up_q && cnt_q == MAXV - 1'b1)); // R7

  AST_OC_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !force_req) |=> $stable(oc_q)); // R9

endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wtmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_clk_in,
  output logic             wave_out,
  output logic             irq_ovf,
  output logic             irq_cmp
);

  logic [2:0]       sel_q;
  wmode_e           mode_q;
  logic [1:0]       act_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic [CNT_W-1:0] cmp_next;
  logic [1:0]       mask_q;
  logic [1:0]       flags_q;
  logic [CNT_W-1:0] cnt;
  logic             tick, ovf_evt, cmp_evt;
  logic             wr_ctrl, wr_cnt, wr_cmp, wr_mask, wr_flag;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
  assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
  assign wr_mask = bus_wr && (bus_addr == A_MASK);
  assign wr_flag = bus_wr && (bus_addr == A_FLAG);
  assign cmp_next = wr_cmp ? bus_wdata : cmp_buf_q;

  wtmr_clkgen #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel_q),
    .ext_in (ext_clk_in),
    .tick   (tick)
  );

  wtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode       (mode_q),
    .act        (act_q),
    .force_req  (wr_ctrl && bus_wdata[7]),
    .force_mode (wmode_e'(bus_wdata[4:3])),
    .force_act  (bus_wdata[6:5]),
    .cnt_wr     (wr_cnt),
    .cnt_wdata  (bus_wdata),
    .cmp_next   (cmp_next),
    .cnt_q      (cnt),
    .oc_q       (wave_out),
    .ovf_evt    (ovf_evt),
    .cmp_evt    (cmp_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      mode_q    <= WM_FREE;
      act_q     <= '0;
      cmp_buf_q <= '0;
      mask_q    <= '0;
      flags_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= bus_wdata[2:0];
        mode_q <= wmode_e'(bus_wdata[4:3]);
        act_q  <= bus_wdata[6:5];
      end
      cmp_buf_q <= cmp_next;
      if (wr_mask) mask_q <= bus_wdata[1:0];
      flags_q[0] <= (flags_q[0] & ~(wr_flag & bus_wdata[0])) | ovf_evt;
      flags_q[1] <= (flags_q[1] & ~(wr_flag & bus_wdata[1])) | cmp_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= CNT_W'({1'b0, act_q, mode_q, sel_q});
        A_COUNT: bus_rdata <= cnt;
        A_CMP:   bus_rdata <= cmp_buf_q;
        A_MASK:  bus_rdata <= CNT_W'(mask_q);
        A_FLAG:  bus_rdata <= CNT_W'(flags_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq_ovf = flags_q[0] & mask_q[0];
  assign irq_cmp = flags_q[1] & mask_q[1];

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && bus_wdata[0] && !ovf_evt) |=> !flags_q[0]); // R10

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    cmp_evt |=> flags_q[1]); // R4

endmodule

// File: tb/test_wave_timer8.sv
module test_wave_timer8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0;
  logic       wave_out, irq_ovf, irq_cmp;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wave_timer8 i_wave_timer8 (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ext_clk_in (ext_clk_in),
    .wave_out   (wave_out),
    .irq_ovf    (irq_ovf),
    .irq_cmp    (irq_cmp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_wr = 1'b0; ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    int v;
    do_reset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R11 register after reset", v, 0);
    end
    check("R11 pin after reset", int'(wave_out), 0);
    check("R11 requests after reset", int'({irq_ovf, irq_cmp}), 0);
  endtask

  task automatic t_prescale();
    int v;
    do_reset();
    wr(3'd0, 8'h02);
    step(79);
    wr(3'd0, 8'h00);
    step(10);
    rd(3'd1, v);
    check("R1 divide-by-8 over 80 clocks", v, 10);
    step(20);
    rd(3'd1, v);
    check("R1 stopped count holds", v, 10);
  endtask

  task automatic t_external();
    int v;
    do_reset();
    wr(3'd0, 8'h07);
    for (int i = 0; i < 5; i++) begin
      ext_clk_in = 1'b1; step(3);
      ext_clk_in = 1'b0; step(3);
    end
    step(4);
    rd(3'd1, v);
    check("R2 rising edges counted", v, 5);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 3; i++) begin
      ext_clk_in = 1'b1; step(3);
      ext_clk_in = 1'b0; step(3);
    end
    step(4);
    rd(3'd1, v);
    check("R2 falling edges counted", v, 8);
  endtask

  task automatic t_free_overflow();
    int v;
    do_reset();
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFD);
    wr(3'd0, 8'h01);
    step(2);
    check("R3 no overflow before wrap", int'(irq_ovf), 0);
    step(1);
    check("R3 overflow on wrap edge", int'(irq_ovf), 1);
    wr(3'd0, 8'h00);
    rd(3'd1, v);
    check("R3 count wrapped past zero", v, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, v);
    check("R10 overflow flag cleared by write-one", v & 1, 0);
    check("R10 overflow request follows flag", int'(irq_ovf), 0);
  endtask

  task automatic t_clr_toggle();
    int v;
    do_reset();
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h31);
    step(3);
    check("R4 pin before first match", int'(wave_out), 0);
    check("R4 no compare request yet", int'(irq_cmp), 0);
    step(1);
    check("R4 pin toggled on match", int'(wave_out), 1);
    check("R4 compare request on match", int'(irq_cmp), 1);
    step(3);
    check("R4 pin steady within period", int'(wave_out), 1);
    step(1);
    check("R4 pin toggled after restart", int'(wave_out), 0);
    wr(3'd0, 8'h00);
    rd(3'd1, v);
    check("R4 count restarted from zero", v, 1);
    wr(3'd3, 8'h00);
    check("R10 mask blocks request", int'(irq_cmp), 0);
    rd(3'd4, v);
    check("R10 flag kept while masked", v, 2);
    wr(3'd4, 8'h02);
    rd(3'd4, v);
    check("R10 compare flag cleared", v, 0);
  endtask

  task automatic t_clr_zero();
    int v;
    int prev;
    do_reset();
    wr(3'd0, 8'h31);
    prev = int'(wave_out);
    for (int i = 0; i < 6; i++) begin
      step(1);
      check("R5 pin flips every tick", int'(wave_out), 1 - prev);
      prev = int'(wave_out);
    end
    wr(3'd0, 8'h00);
    rd(3'd1, v);
    check("R5 count stays at zero", v, 0);
  endtask

  task automatic t_saw(input logic [7:0] ctrl, input int exp_high, input string msg);
    int highs;
    do_reset();
    wr(3'd2, 8'h40);
    wr(3'd1, 8'hFF);
    wr(3'd0, ctrl);
    step(1);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_out) highs++;
      step(1);
    end
    check(msg, highs, exp_high);
  endtask

  task automatic t_buffer();
    int highs;
    do_reset();
    wr(3'd2, 8'h40);
    wr(3'd0, 8'h78);
    wr(3'd2, 8'h80);
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h79);
    step(48);
    check("R8 pin low before old compare", int'(wave_out), 0);
    step(1);
    check("R8 old compare still active", int'(wave_out), 1);
    step(240 - 49);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_out) highs++;
      step(1);
    end
    check("R8 new compare after top", highs, 127);
  endtask

  task automatic t_triangle();
    do_reset();
    wr(3'd2, 8'h80);
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h69);
    step(128);
    check("R7 pin before rising match", int'(wave_out), 0);
    step(1);
    check("R7 inverting set on rising match", int'(wave_out), 1);
    step(253);
    check("R7 pin before falling match", int'(wave_out), 1);
    check("R7 no overflow at top", int'(irq_ovf), 0);
    step(1);
    check("R7 inverting clear on falling match", int'(wave_out), 0);
    step(126);
    check("R7 no overflow before bottom", int'(irq_ovf), 0);
    step(1);
    check("R7 overflow at one-to-zero step", int'(irq_ovf), 1);
  endtask

  task automatic t_force();
    int v;
    do_reset();
    wr(3'd0, 8'hF0);
    check("R9 forced set applied", int'(wave_out), 1);
    rd(3'd0, v);
    check("R9 strobe reads zero", v, 8'h70);
    rd(3'd4, v);
    check("R9 strobe sets no flag", v, 0);
    rd(3'd1, v);
    check("R9 strobe leaves count", v, 0);
    wr(3'd0, 8'hB0);
    check("R9 forced toggle applied", int'(wave_out), 0);
    wr(3'd0, 8'hF8);
    step(2);
    check("R9 strobe ignored in PWM mode", int'(wave_out), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    report();
    $finish;
  end

  initial begin
    t_reset_state();
    t_prescale();
    t_external();
    t_free_overflow();
    t_clr_toggle();
    t_clr_zero();
    t_saw(8'h59, 65, "R6 non-inverting saw duty");
    t_saw(8'h79, 191, "R6 inverting saw duty");
    t_buffer();
    t_triangle();
    t_force();
    report();
    $finish;
  end

endmodule